// File: doc/BRIEF.md
# Load Queue Ordering Violation Detector

This block is the load side of speculative memory disambiguation in an out-of-order core. Loads may run ahead of older stores whose addresses are still unknown. Each load takes a slot in a circular queue at dispatch. The slot holds the load's program-order age, and once the load runs it also holds the load's address and a performed flag. The head slot is released when the load retires.

When an older store finally computes its address, the store presents its age and address. Every live slot compares against it in parallel. A slot is a violator when it holds a load that is younger than the store, has already performed, and reads the same address. The queue selects the violator closest to the head, which is the oldest one. One cycle later it reports that load's age, so the pipeline can squash everything from that load onward, including the load itself, and refetch. A flush input trims the queue back to a given age after such a squash.

Ages come from a wrapping counter. Age `x` is younger than age `y` when `(x - y) mod 2^AGE_W` lies in `1 .. 2^(AGE_W-1)-1`. The live window of ages must therefore stay under half the counter range. `DEPTH` must be a power of two.

Top module: `lq_viol_detect`

## Requirements
- R1: While `rst` is high, the queue empties on each clock: `lq_count` = 0, `tail_idx` = 0, `lq_full` = 0, `viol_valid` = 0.
- R2: When `alloc_valid` is high and the queue is not full, a clock writes `alloc_age` into slot `tail_idx`, advances `tail_idx` by one modulo `DEPTH` and raises `lq_count` by one. `lq_full` is high exactly when `lq_count` = `DEPTH`. An allocation while full changes nothing.
- R3: `exec_valid` marks the live slot `exec_idx` as performed and stores `exec_addr` in it. A newly allocated slot always starts as not performed.
- R4: `retire_valid` frees the head slot and lowers `lq_count` by one. On an empty queue it has no effect.
- R5: A store search (`st_valid`) finds a violation when some live slot is performed, holds an address equal to `st_addr`, and holds an age younger than `st_age` under the wrapping rule above.
- R6: The search ignores slots that are not performed, slots whose age is equal to or older than the store's, slots with a different address, and freed slots.
- R7: When several slots qualify, `viol_age` gives the age of the one nearest the head, which is the oldest.
- R8: `viol_valid` is a one-cycle pulse on the clock after the `st_valid` cycle. The search sees the queue as it stood at the start of that cycle.
- R9: `flush_valid` removes every live slot whose age is equal to or younger than `flush_age`. `lq_count` drops to the number of older slots and `tail_idx` moves back to follow them. In a flush cycle, `alloc_valid` and `retire_valid` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a slot at the tail |
| alloc_age | input | AGE_W | Age of the dispatched load |
| exec_valid | input | 1 | A load has performed |
| exec_idx | input | log2(DEPTH) | Slot of the performed load |
| exec_addr | input | ADDR_W | Address the load read |
| retire_valid | input | 1 | Free the head slot |
| st_valid | input | 1 | A store address was computed |
| st_age | input | AGE_W | Age of that store |
| st_addr | input | ADDR_W | Address of that store |
| flush_valid | input | 1 | Drop slots at or younger than `flush_age` |
| flush_age | input | AGE_W | Oldest age to drop |
| tail_idx | output | log2(DEPTH) | Slot the next allocation takes |
| lq_count | output | log2(DEPTH)+1 | Number of live slots |
| lq_full | output | 1 | Queue full |
| viol_valid | output | 1 | Violation pulse |
| viol_age | output | AGE_W | Age of the oldest violating load |

## Verification
The bench sweeps every subset of performed loads in a full queue. It pairs each subset with every store position relative to the loads and with two address classes, while the ages wrap around the counter and the head moves to every slot. Getting the age compare wrong, for example with a plain magnitude compare or by counting an equal age as younger, shows up as false or missed violations near the wrap point. A picker that scans from slot 0 rather than from the head reports a younger load whenever the queue has wrapped. Directed cases cover the following: allocation while full and retirement while empty, which would corrupt the count; a flush that leaves stale performed slots behind, which would give phantom violations; and reused slots that keep an old performed flag.

// File: rtl/lq_pkg.sv
package lq_pkg;
  parameter int LQ_DEPTH  = 8;
  parameter int LQ_AGE_W  = 6;
  parameter int LQ_ADDR_W = 16;
endpackage

// File: rtl/lq_cam_row.sv
// One queue slot's comparators: store-search hit and flush age test.
module lq_cam_row #(
  parameter int AGE_W  = lq_pkg::LQ_AGE_W,
  parameter int ADDR_W = lq_pkg::LQ_ADDR_W
) (
  input  logic              live,
  input  logic              done,
  input  logic [AGE_W-1:0]  ld_age,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [AGE_W-1:0]  st_age,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [AGE_W-1:0]  flush_age,
  output logic              hit,
  output logic              keep
);
  logic [AGE_W-1:0] d_st;
  logic [AGE_W-1:0] d_fl;
  logic             ld_younger;

  always_comb begin
    d_st       = ld_age - st_age;
    ld_younger = (d_st != '0) && !d_st[AGE_W-1];
    hit        = live && done && ld_younger && (ld_addr == st_addr);
    // Slot survives a flush when strictly older than the flush age.
    d_fl       = flush_age - ld_age;
    keep       = live && (d_fl != '0) && !d_fl[AGE_W-1];
  end
endmodule

// File: rtl/lq_oldest_pick.sv
// Picks the first set hit bit counting from the head slot.
module lq_oldest_pick #(
  parameter int DEPTH = lq_pkg::LQ_DEPTH,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] hit,
  input  logic [IDX_W-1:0] head,
  output logic             found,
  output logic [IDX_W-1:0] sel
);
  always_comb begin
    found = 1'b0;
    sel   = head;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit[head + IDX_W'(i)]) begin
        found = 1'b1;
        sel   = head + IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lq_viol_detect.sv
module lq_viol_detect #(
  parameter int DEPTH  = lq_pkg::LQ_DEPTH,
  parameter int AGE_W  = lq_pkg::LQ_AGE_W,
  parameter int ADDR_W = lq_pkg::LQ_ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc_valid,
  input  logic [AGE_W-1:0]         alloc_age,
  input  logic                     exec_valid,
  input  logic [$clog2(DEPTH)-1:0] exec_idx,
  input  logic [ADDR_W-1:0]        exec_addr,
  input  logic                     retire_valid,
  input  logic                     st_valid,
  input  logic [AGE_W-1:0]         st_age,
  input  logic [ADDR_W-1:0]        st_addr,
  input  logic                     flush_valid,
  input  logic [AGE_W-1:0]         flush_age,
  output logic [$clog2(DEPTH)-1:0] tail_idx,
  output logic [$clog2(DEPTH):0]   lq_count,
  output logic                     lq_full,
  output logic                     viol_valid,
  output logic [AGE_W-1:0]         viol_age
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = IDX_W + 1;

  logic [IDX_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q;
  logic [AGE_W-1:0]  age_mem  [DEPTH];
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DEPTH-1:0]  done_q;
  logic [DEPTH-1:0]  live, hit, keep;
  logic [CNT_W-1:0]  keep_cnt;
  logic              do_alloc, do_ret, do_exec;
  logic              found;
  logic [IDX_W-1:0]  sel;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      live[i] = {1'b0, IDX_W'(i) - head_q} < count_q;
    end
    keep_cnt = '0;
    for (int i = 0; i < DEPTH; i++) keep_cnt = keep_cnt + CNT_W'(keep[i]);
  end

  assign lq_full  = (count_q == CNT_W'(DEPTH));
  assign do_alloc = alloc_valid && !lq_full && !flush_valid;
  assign do_ret   = retire_valid && (count_q != '0) && !flush_valid;
  assign do_exec  = exec_valid && live[exec_idx];
  assign tail_idx = tail_q;
  assign lq_count = count_q;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
      lq_cam_row #(.AGE_W(AGE_W), .ADDR_W(ADDR_W)) i_row (
        .live(live[g]), .done(done_q[g]), .ld_age(age_mem[g]),
        .ld_addr(addr_mem[g]), .st_age(st_age), .st_addr(st_addr),
        .flush_age(flush_age), .hit(hit[g]), .keep(keep[g]));
    end
  endgenerate

  lq_oldest_pick #(.DEPTH(DEPTH)) i_pick (
    .hit(hit), .head(head_q), .found(found), .sel(sel));

  // Payload storage, no reset, one write port per array.
  always_ff @(posedge clk) begin
    if (do_alloc) age_mem[tail_q] <= alloc_age;
    if (do_exec)  addr_mem[exec_idx] <= exec_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q     <= '0;
      tail_q     <= '0;
      count_q    <= '0;
      done_q     <= '0;
      viol_valid <= 1'b0;
      viol_age   <= '0;
    end else begin
      viol_valid <= st_valid && found;
      viol_age   <= age_mem[sel];
      if (do_exec)  done_q[exec_idx] <= 1'b1;
      if (do_alloc) done_q[tail_q]   <= 1'b0;
      if (flush_valid) begin
        count_q <= keep_cnt;
        tail_q  <= head_q + keep_cnt[IDX_W-1:0];
      end else begin
        count_q <= count_q + CNT_W'(do_alloc) - CNT_W'(do_ret);
        if (do_alloc) tail_q <= tail_q + 1'b1;
        if (do_ret)   head_q <= head_q + 1'b1;
      end
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (lq_count == '0 && !viol_valid && tail_idx == '0));

  // R2
  count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    lq_count <= CNT_W'(DEPTH));

  // R2
  full_alloc_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (lq_full && alloc_valid && !retire_valid && !flush_valid)
      |=> ($stable(lq_count) && $stable(tail_idx)));

  // R4
  empty_retire_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (lq_count == '0 && retire_valid && !alloc_valid && !flush_valid)
      |=> (lq_count == '0));

  // R9
  flush_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
    flush_valid |=> (lq_count <= $past(lq_count)));

  // R8
  viol_after_store_chk: assert property (@(posedge clk) disable iff (rst)
    viol_valid |-> $past(st_valid));

  // R5
  viol_younger_chk: assert property (@(posedge clk) disable iff (rst)
    viol_valid |-> ((AGE_W'(viol_age - $past(st_age)) != '0) &&
                    !(AGE_W'(viol_age - $past(st_age)) >> (AGE_W - 1))));
endmodule

// File: tb/test_lq_viol_detect.sv
module test_lq_viol_detect;
  localparam int CLK_PERIOD = 10;
  localparam int D = 4, AW = 4, DW = 4;

  logic clk = 1'b0;
  logic rst;
  logic alloc_valid, exec_valid, retire_valid, st_valid, flush_valid;
  logic [AW-1:0] alloc_age, st_age, flush_age, viol_age;
  logic [1:0]    exec_idx, tail_idx;
  logic [DW-1:0] exec_addr, st_addr;
  logic [2:0]    lq_count;
  logic          lq_full, viol_valid;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lq_viol_detect #(.DEPTH(D), .AGE_W(AW), .ADDR_W(DW)) i_lq_viol_detect (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_age(alloc_age),
    .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
    .retire_valid(retire_valid), .st_valid(st_valid), .st_age(st_age),
    .st_addr(st_addr), .flush_valid(flush_valid), .flush_age(flush_age),
    .tail_idx(tail_idx), .lq_count(lq_count), .lq_full(lq_full),
    .viol_valid(viol_valid), .viol_age(viol_age));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic alloc(input int age);
    alloc_valid = 1'b1; alloc_age = AW'(age); tick(); alloc_valid = 1'b0;
  endtask

  task automatic exec(input int idx, input int addr);
    exec_valid = 1'b1; exec_idx = 2'(idx); exec_addr = DW'(addr);
    tick(); exec_valid = 1'b0;
  endtask

  task automatic store(input int age, input int addr, input bit e_hit,
                       input int e_age, input string req);
    st_valid = 1'b1; st_age = AW'(age); st_addr = DW'(addr);
    tick(); st_valid = 1'b0;
    chk(viol_valid == e_hit, req, viol_valid, e_hit);
    if (e_hit) chk(viol_age == AW'(e_age), {req, " R7 age"}, viol_age, e_age % 16);
    tick();
    chk(!viol_valid, "R8 pulse", viol_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int h;
    rst = 1'b1; alloc_valid = 0; exec_valid = 0; retire_valid = 0;
    st_valid = 0; flush_valid = 0; alloc_age = 0; st_age = 0; flush_age = 0;
    exec_idx = 0; exec_addr = 0; st_addr = 0;
    repeat (3) tick();
    // R1
    chk(lq_count == 0 && !lq_full && !viol_valid && tail_idx == 0, "R1 reset",
        lq_count, 0);
    rst = 1'b0;
    h = 0;

    for (int it = 0; it < 160; it++) begin
      int mask, s, a, base, e_age;
      bit e_hit;
      mask = it % 16; s = (it / 16) % 5; a = it / 80; base = (it * 5) % 16;
      for (int k = 0; k < 4; k++) begin
        chk(tail_idx == 2'((h + k) % 4), "R2 tail", tail_idx, (h + k) % 4);
        alloc(base + 2 * k);
      end
      chk(lq_count == 4 && lq_full, "R2 full", lq_count, 4);
      for (int k = 0; k < 4; k++)
        if (mask[k]) exec((h + k) % 4, k & 1);
      e_hit = 0; e_age = 0;
      for (int k = 3; k >= s; k--)
        if (mask[k] && (k & 1) == a) begin e_hit = 1; e_age = base + 2 * k; end
      store(base + 2 * s - 1, a, e_hit, e_age, "R5 R6 sweep");
      retire_valid = 1'b1; repeat (4) tick(); retire_valid = 1'b0;
      chk(lq_count == 0, "R4 drain", lq_count, 0);
      alloc(base); retire_valid = 1'b1; tick(); retire_valid = 1'b0;
      h = (h + 1) % 4;
    end

    // R2: allocation while full is ignored
    for (int k = 0; k < 4; k++) alloc(2 * k);
    alloc(9);
    chk(lq_count == 4 && tail_idx == 2'(h), "R2 alloc when full", tail_idx, h);
    for (int k = 0; k < 4; k++) exec((h + k) % 4, 5);
    // R9: flush from age 4, concurrent alloc ignored
    flush_valid = 1'b1; flush_age = 4'd4; alloc_valid = 1'b1; alloc_age = 4'd3;
    tick(); flush_valid = 1'b0; alloc_valid = 1'b0;
    chk(lq_count == 2, "R9 count", lq_count, 2);
    chk(tail_idx == 2'((h + 2) % 4), "R9 tail", tail_idx, (h + 2) % 4);
    store(15, 5, 1, 0, "R9 R7 survivors");
    store(1, 5, 1, 2, "R7 younger of two");
    store(3, 5, 0, 0, "R9 flushed not seen");
    retire_valid = 1'b1; repeat (2) tick();
    // R4: retire on empty
    tick(); retire_valid = 1'b0;
    chk(lq_count == 0, "R4 retire empty", lq_count, 0);
    h = (h + 2) % 4;

    for (int k = 0; k < 4; k++) alloc(8 + 2 * k);
    exec((h + 2) % 4, 5); exec((h + 3) % 4, 5);
    flush_valid = 1'b1; flush_age = 4'd12; tick(); flush_valid = 1'b0;
    store(7, 5, 0, 0, "R9 stale performed slots");
    // R3: reused slot starts not performed
    alloc(12);
    store(7, 5, 0, 0, "R3 reuse cleared");
    exec((h + 2) % 4, 5);
    store(7, 5, 1, 12, "R3 exec marks");
    store(7, 6, 0, 0, "R6 address mismatch");
    store(12, 5, 0, 0, "R6 equal age");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule